// File: doc/BRIEF.md
# USB Control Endpoint SETUP Capture

This block sits between a USB serial engine and a small local CPU. It watches a simplified token/data stream: a strobe for each SETUP token, a strobe with a byte for each received data byte, and an end-of-packet strobe that carries a CRC-good flag. After a SETUP token it stores the data bytes of the following packet in an eight-entry buffer. When the packet holds exactly eight bytes and its CRC is good, it raises a request telling the CPU that new request data is waiting.

The CPU reaches the block through a byte-wide register port. Read data is registered and appears one cycle after the address. Addresses 0 to 7 return the captured bytes. Address 8 holds the two request flags: bit 0 is the token warning and bit 1 is data-ready. Both flags are write-one-to-clear. Address 9 holds the matching enable bits, in the same bit positions. Address 10 is the endpoint-zero control register: bit 0 is stall and bit 1 is handshake-NAK. Any other address reads as zero.

The interrupt line is high while any request flag is set together with its enable. Every SETUP token is accepted, even while the CPU is still handling the previous request. A new token restarts capture from the first buffer entry and clears the stall bit.

Top module: `usb_ctl_setup_capture`

## Requirements
- R1: After reset, every register address (0 to 10) reads 0, `irq_o` is 0, and `ep0_stall_o` and `ep0_hsnak_o` are 0.
- R2: A cycle with `tok_setup_i` high sets the token-warning request (bit 0 of address 8) on the next cycle.
- R3: After a token, the data bytes are stored in arrival order at buffer entries 0 through 7. Each entry can be read back at the address equal to its index.
- R4: A packet of exactly 8 bytes that ends with `rx_crc_ok_i` high sets the data-ready request (bit 1 of address 8).
- R5: A packet with a CRC error, or with fewer or more than 8 bytes, does not set data-ready. Its first bytes (up to 8 of them) still overwrite the buffer.
- R6: Writing address 8 clears each request whose bit in the write data is 1. Request bits written with 0 keep their value.
- R7: If a request is set by hardware in the same cycle that the CPU writes 1 to clear it, the request ends up set.
- R8: `irq_o` equals (bit 0 of address 8 AND bit 0 of address 9) OR (bit 1 of address 8 AND bit 1 of address 9). The request bits read back the same whatever the enables are.
- R9: The CPU writes stall (bit 0) and handshake-NAK (bit 1) at address 10. The next SETUP token clears stall and leaves handshake-NAK unchanged.
- R10: A SETUP token that arrives while a packet is still being captured abandons that packet and restarts capture at entry 0.
- R11: Data bytes that arrive with no SETUP token before them since the last end-of-packet are ignored. CPU writes to addresses 0 to 7 do not change the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_setup_i | input | 1 | One-cycle strobe: a SETUP token was received |
| rx_valid_i | input | 1 | One-cycle strobe: `rx_data_i` holds a received byte |
| rx_data_i | input | 8 | Received data byte |
| rx_eop_i | input | 1 | One-cycle strobe: end of the data packet |
| rx_crc_ok_i | input | 1 | Packet CRC was good; sampled with `rx_eop_i` |
| cpu_addr_i | input | 4 | Register address |
| cpu_wr_i | input | 1 | Register write strobe |
| cpu_wdata_i | input | 8 | Register write data |
| cpu_rdata_o | output | 8 | Read data, valid one cycle after the address |
| irq_o | output | 1 | Interrupt level |
| ep0_stall_o | output | 1 | Endpoint-zero stall bit |
| ep0_hsnak_o | output | 1 | Endpoint-zero handshake-NAK bit |

## Verification
The hardest case to reach is a hardware set and a CPU clear landing in the same cycle. The bench first clears the token warning, then raises the token strobe and a write of 1 to address 8 on one edge, and checks that the flag stays set.

Pre-emption is also hard to reach from the ports. The bench sends a token and a few bytes, then a second token without an end-of-packet in between, and checks that the second packet fills the buffer from entry 0 and is accepted.

A final sweep covers every combination of request and enable. It builds each request pattern from real packets and targeted clears, so each interrupt value comes from a reachable state.

// File: rtl/setup_cap_pkg.sv
package setup_cap_pkg;
  // offsets of the control registers above the capture buffer
  localparam int OFS_REQ = 0;
  localparam int OFS_EN  = 1;
  localparam int OFS_EP0 = 2;
  // bit positions shared by request and enable registers
  localparam int BIT_TOK  = 0;
  localparam int BIT_DATA = 1;
  // bit positions in the endpoint-zero control register
  localparam int BIT_STALL = 0;
  localparam int BIT_HSNAK = 1;

  typedef struct packed {
    logic data;
    logic tok;
  } req_pair_t;
endpackage

// File: rtl/setup_stream_rx.sv
module setup_stream_rx #(
  parameter int SETUP_BYTES = 8,
  parameter int DATA_W      = 8,
  localparam int IDX_W      = $clog2(SETUP_BYTES),
  localparam int CNT_W      = $clog2(SETUP_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_setup_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_eop_i,
  input  logic              rx_crc_ok_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              pkt_good_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SETUP_BYTES);

  logic             armed_q;
  logic             bad_q;
  logic [CNT_W-1:0] cnt_q;
  logic             room;

  assign room       = cnt_q < FULL;
  assign wr_en_o    = armed_q && rx_valid_i && !rx_eop_i && !tok_setup_i && room;
  assign wr_idx_o   = cnt_q[IDX_W-1:0];
  assign wr_data_o  = rx_data_i;
  assign pkt_good_o = armed_q && !tok_setup_i && rx_eop_i && rx_crc_ok_i &&
                      !bad_q && (cnt_q == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      bad_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (tok_setup_i) begin
      armed_q <= 1'b1;
      bad_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (armed_q) begin
      if (rx_eop_i) begin
        armed_q <= 1'b0;
      end else if (rx_valid_i) begin
        if (room) cnt_q <= cnt_q + 1'b1;
        else      bad_q <= 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL); // R3
  AST_TOK_RESTART: assert property (@(posedge clk) disable iff (rst)
    tok_setup_i |=> (cnt_q == '0) && armed_q); // R10
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> !wr_en_o); // R11
endmodule

// File: rtl/setup_buffer.sv
module setup_buffer #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_data_o <= '0;
    end else begin
      if (wr_en_i) mem[wr_idx_i] <= wr_data_i;
      rd_data_o <= mem[rd_idx_i];
    end
  end
endmodule

// File: rtl/setup_irq_regs.sv
module setup_irq_regs
  import setup_cap_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      set_tok_i,
  input  logic      set_data_i,
  input  logic      wr_req_i,
  input  logic      wr_en_i,
  input  logic      wr_ep0_i,
  input  logic [1:0] wdata_i,
  output req_pair_t req_o,
  output req_pair_t en_o,
  output logic      stall_o,
  output logic      hsnak_o,
  output logic      irq_o
);
  req_pair_t set_v, clr_v;

  always_comb begin
    set_v.tok  = set_tok_i;
    set_v.data = set_data_i;
    clr_v.tok  = wr_req_i && wdata_i[BIT_TOK];
    clr_v.data = wr_req_i && wdata_i[BIT_DATA];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o   <= '0;
      en_o    <= '0;
      stall_o <= 1'b0;
      hsnak_o <= 1'b0;
    end else begin
      req_o <= (req_o & ~clr_v) | set_v;
      if (wr_en_i) begin
        en_o.tok  <= wdata_i[BIT_TOK];
        en_o.data <= wdata_i[BIT_DATA];
      end
      if (wr_ep0_i) hsnak_o <= wdata_i[BIT_HSNAK];
      if (set_tok_i)     stall_o <= 1'b0;
      else if (wr_ep0_i) stall_o <= wdata_i[BIT_STALL];
    end
  end

  assign irq_o = |(req_o & en_o);

  AST_TOK_SETS_REQ: assert property (@(posedge clk) disable iff (rst)
    set_tok_i |=> req_o.tok); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_data_i && wr_req_i && wdata_i[BIT_DATA]) |=> req_o.data); // R7
  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_req_i && wdata_i[BIT_TOK] && !set_tok_i) |=> !req_o.tok); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_req_i && !set_tok_i && !set_data_i) |=> $stable(req_o)); // R6
  AST_DATA_ONLY_GOOD: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o.data) |-> $past(set_data_i)); // R5
  AST_STALL_CLR: assert property (@(posedge clk) disable iff (rst)
    set_tok_i |=> !stall_o); // R9
endmodule

// File: rtl/usb_ctl_setup_capture.sv
module usb_ctl_setup_capture
  import setup_cap_pkg::*;
#(
  parameter int SETUP_BYTES = 8,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_setup_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_eop_i,
  input  logic              rx_crc_ok_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              irq_o,
  output logic              ep0_stall_o,
  output logic              ep0_hsnak_o
);
  localparam int IDX_W = $clog2(SETUP_BYTES);
  localparam logic [ADDR_W-1:0] A_REQ = ADDR_W'(SETUP_BYTES + OFS_REQ);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(SETUP_BYTES + OFS_EN);
  localparam logic [ADDR_W-1:0] A_EP0 = ADDR_W'(SETUP_BYTES + OFS_EP0);
  localparam logic [ADDR_W-1:0] A_BUF_END = ADDR_W'(SETUP_BYTES);

  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic              pkt_good;
  logic [DATA_W-1:0] buf_rd;
  req_pair_t         req, en;
  logic              sel_buf_q;
  logic [DATA_W-1:0] reg_rd_q;

  setup_stream_rx #(.SETUP_BYTES(SETUP_BYTES), .DATA_W(DATA_W)) rx_i (
    .clk, .rst, .tok_setup_i, .rx_valid_i, .rx_data_i, .rx_eop_i, .rx_crc_ok_i,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .pkt_good_o(pkt_good)
  );

  setup_buffer #(.DEPTH(SETUP_BYTES), .DATA_W(DATA_W)) buf_i (
    .clk, .rst, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(cpu_addr_i[IDX_W-1:0]), .rd_data_o(buf_rd)
  );

  setup_irq_regs regs_i (
    .clk, .rst,
    .set_tok_i(tok_setup_i), .set_data_i(pkt_good),
    .wr_req_i(cpu_wr_i && cpu_addr_i == A_REQ),
    .wr_en_i (cpu_wr_i && cpu_addr_i == A_EN),
    .wr_ep0_i(cpu_wr_i && cpu_addr_i == A_EP0),
    .wdata_i(cpu_wdata_i[1:0]),
    .req_o(req), .en_o(en), .stall_o(ep0_stall_o), .hsnak_o(ep0_hsnak_o),
    .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_buf_q <= 1'b0;
      reg_rd_q  <= '0;
    end else begin
      sel_buf_q <= cpu_addr_i < A_BUF_END;
      reg_rd_q  <= '0;
      if (cpu_addr_i == A_REQ) reg_rd_q[1:0] <= {req.data, req.tok};
      if (cpu_addr_i == A_EN)  reg_rd_q[1:0] <= {en.data, en.tok};
      if (cpu_addr_i == A_EP0) reg_rd_q[1:0] <= {ep0_hsnak_o, ep0_stall_o};
    end
  end

  assign cpu_rdata_o = sel_buf_q ? buf_rd : reg_rd_q;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |-> !irq_o); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && !ep0_stall_o && cpu_rdata_o == '0)); // R1
endmodule

// File: tb/usb_ctl_setup_capture_tb_top.sv
module usb_ctl_setup_capture_tb_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tok = 0, vld = 0, eop = 0, crc = 0, wr = 0;
  logic [7:0] rxd = 0, wdat = 0, rdata;
  logic [3:0] addr = 0;
  logic irq, stall, hsnak;

  int checks = 0, errors = 0;
  int exp_buf [8];
  logic [7:0] v;

  always #(PERIOD/2) clk = ~clk;

  usb_ctl_setup_capture dut_i (
    .clk, .rst, .tok_setup_i(tok), .rx_valid_i(vld), .rx_data_i(rxd),
    .rx_eop_i(eop), .rx_crc_ok_i(crc), .cpu_addr_i(addr), .cpu_wr_i(wr),
    .cpu_wdata_i(wdat), .cpu_rdata_o(rdata), .irq_o(irq),
    .ep0_stall_o(stall), .ep0_hsnak_o(hsnak)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_tok(); tok = 1; tick(); tok = 0; endtask
  task automatic send_byte(input logic [7:0] d); vld = 1; rxd = d; tick(); vld = 0; endtask
  task automatic send_eop(input logic ok); eop = 1; crc = ok; tick(); eop = 0; crc = 0; endtask
  task automatic cpu_write(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdat = d; wr = 1; tick(); wr = 0;
  endtask
  task automatic cpu_read(input logic [3:0] a, output logic [7:0] d);
    addr = a; tick(); d = rdata;
  endtask

  function automatic logic [7:0] pat(int p, int i);
    return 8'((p * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic packet(int p, int n, logic ok);
    send_tok();
    for (int i = 0; i < n; i++) begin
      send_byte(pat(p, i));
      if (i < 8) exp_buf[i] = int'(pat(p, i));
    end
    send_eop(ok);
  endtask

  task automatic check_buf(string req);
    for (int i = 0; i < 8; i++) begin
      cpu_read(4'(i), v);
      check(req, int'(v), exp_buf[i]);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_buf[i] = 0;
    repeat (3) tick();
    rst = 0;
    // R1: reset state on every address
    for (int a = 0; a <= 10; a++) begin
      cpu_read(4'(a), v);
      check("R1", int'(v), 0);
    end
    check("R1 irq", int'(irq), 0);
    check("R1 stall", int'(stall), 0);
    check("R1 hsnak", int'(hsnak), 0);

    // R2..R6: packet sweep with good and faulty endings
    for (int p = 0; p < 6; p++) begin
      int n;
      logic ok, good;
      n = (p == 3) ? 7 : (p == 4) ? 9 : 8;
      ok = (p != 2);
      good = ok && (n == 8);
      send_tok();
      cpu_read(4'd8, v);
      check("R2", int'(v[0]), 1);
      exp_buf = exp_buf;
      for (int i = 0; i < n; i++) begin
        send_byte(pat(p, i));
        if (i < 8) exp_buf[i] = int'(pat(p, i));
      end
      send_eop(ok);
      cpu_read(4'd8, v);
      check(good ? "R4" : "R5", int'(v[1]), int'(good));
      check_buf(good ? "R3" : "R5");
      cpu_write(4'd8, 8'h03);
      cpu_read(4'd8, v);
      check("R6", int'(v), 0);
    end

    // R6: write 0 keeps, write one bit clears only that bit
    packet(10, 8, 1);
    cpu_write(4'd8, 8'h00);
    cpu_read(4'd8, v);
    check("R6 zero", int'(v), 3);
    cpu_write(4'd8, 8'h01);
    cpu_read(4'd8, v);
    check("R6 bit", int'(v), 2);
    cpu_write(4'd8, 8'h03);

    // R7: set and clear in the same cycle
    tok = 1; addr = 4'd8; wdat = 8'h01; wr = 1; tick(); tok = 0; wr = 0;
    cpu_read(4'd8, v);
    check("R7", int'(v[0]), 1);
    send_eop(0);
    cpu_write(4'd8, 8'h03);

    // R8: every request/enable combination
    for (int r = 0; r < 4; r++) begin
      for (int e = 0; e < 4; e++) begin
        cpu_write(4'd8, 8'h03);
        if (r[1]) packet(20 + r, 8, 1);
        else if (r[0]) begin send_tok(); send_eop(0); end
        if (r == 2) cpu_write(4'd8, 8'h01);
        cpu_write(4'd9, 8'(e));
        check("R8 irq", int'(irq), int'((r & e) != 0));
        cpu_read(4'd8, v);
        check("R8 poll", int'(v), r);
      end
    end
    cpu_write(4'd9, 8'h00);
    cpu_write(4'd8, 8'h03);

    // R9: stall cleared by token, handshake-NAK kept
    cpu_write(4'd10, 8'h03);
    cpu_read(4'd10, v);
    check("R9 set", int'(v), 3);
    check("R9 pin", int'(stall), 1);
    send_tok();
    cpu_read(4'd10, v);
    check("R9 clr", int'(v), 2);
    check("R9 pin", int'(stall), 0);
    check("R9 nak", int'(hsnak), 1);
    send_eop(0);
    cpu_write(4'd10, 8'h00);
    cpu_write(4'd8, 8'h03);

    // R10: a second token pre-empts a partial packet
    send_tok();
    for (int i = 0; i < 4; i++) send_byte(8'hA0 + 8'(i));
    packet(30, 8, 1);
    cpu_read(4'd8, v);
    check("R10 req", int'(v[1]), 1);
    check_buf("R10");

    // R11: stray bytes and CPU writes leave the buffer unchanged
    for (int i = 0; i < 8; i++) send_byte(8'h55);
    cpu_write(4'd0, 8'hFF);
    cpu_write(4'd7, 8'hFF);
    check_buf("R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule